// File: doc/BRIEF.md
# I2C Receive Slave with Busy-Buffer Refusal

This block is a receive-only I2C target. It oversamples the open-drain SCL and SDA lines in the system clock domain and finds START and STOP conditions. It shifts each bit in on the rising edge of SCL and compares the first one or two bytes of a transfer against a programmable own address. Matching can use a 7-bit or a 10-bit address. Once the block is addressed, it acknowledges data bytes and hands them to a host through a small register port. An interrupt line tells the host when a byte has arrived.

The receive buffer holds a single byte. The host must read the buffer before the next byte arrives. If a byte completes while the buffer is still full, or while the sticky overflow flag is set, the block refuses it. It leaves SDA released in the acknowledge slot and keeps the buffer contents. The interrupt is still raised, so the host learns about the refused byte. The host clears the overflow flag explicitly to resume reception.

Top module: `i2c_rx_slave`

## Requirements
- R1: In 7-bit mode (control bit 1 = 0), an address byte whose bits [7:1] equal address-low register bits [6:0] and whose bit 0 (R/W) is 0 is acknowledged by pulling SDA low for the ninth SCL period. Any other first byte is not acknowledged, and the data bytes that follow it are ignored until the next START.
- R2: In 10-bit mode (control bit 1 = 1), the first byte must be 11110, then address-high bits [1:0], then R/W = 0. The second byte must equal the address-low register. Both bytes are acknowledged. If the second byte does not match, it is not acknowledged and the data that follows is ignored.
- R3: A data byte received while addressed, with status bit 0 (buffer full) and status bit 1 (overflow) both clear, is acknowledged. The byte is copied to the receive buffer (register 2), buffer full is set, and the interrupt flag (status bit 4, driven on irq_o) is set.
- R4: A data byte that completes while buffer full is set is not acknowledged. The receive buffer is unchanged, the overflow flag is set, and the interrupt flag is set.
- R5: A data byte that completes while overflow is set and buffer full is clear is also not acknowledged. The receive buffer is unchanged and the interrupt flag is set.
- R6: A host read of register 2 clears buffer full. Writing status with bit 1 = 1 clears overflow, and nothing else clears it. Writing status with bit 4 = 1 clears the interrupt flag.
- R7: A START (SDA falling while SCL is high) sets status bit 2 and clears status bit 3. A STOP (SDA rising while SCL is high) sets bit 3 and clears bit 2. When control bit 2 is set, each of them also sets the interrupt flag.
- R8: SDA is only ever pulled low, and only from the SCL falling edge after the eighth bit to the SCL falling edge after the ninth. Otherwise it is released.
- R9: After reset, the control, status and address registers read 0 and irq_o is low.
- R10: With control bit 0 (enable) clear, no byte is acknowledged and START/STOP do not update status.
- R11: An address byte with R/W = 1 is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr_i | input | 3 | Register select: 0 control, 1 status, 2 receive buffer, 3 address low, 4 address high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect on register 2) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt flag |

## Verification
The hardest state to reach is overflow with the buffer already empty. In that state the refusal comes only from the sticky flag. To reach it, the bench leaves a byte unread so the next byte overflows. It then reads the buffer to clear the full flag while the overflow flag stays set. It sends one more byte and expects a NACK, an unchanged buffer and a fresh interrupt. A 10-bit transfer with a wrong low byte after a repeated START checks that a half-matched address locks out the data that follows.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL    = 3'd0,
    REG_STAT    = 3'd1,
    REG_RXBUF   = 3'd2,
    REG_ADDR_LO = 3'd3,
    REG_ADDR_HI = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_ADDR1, PH_ADDR2, PH_DATA, PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    BS_IDLE, BS_BITS, BS_WAIT, BS_SLOT, BS_HOLD
  } bit_st_e;

  // status bit positions
  localparam int ST_FULL = 0;
  localparam int ST_OVF  = 1;
  localparam int ST_S    = 2;
  localparam int ST_P    = 3;
  localparam int ST_IRQ  = 4;
  // control bit positions
  localparam int CT_EN   = 0;
  localparam int CT_TEN  = 1;
  localparam int CT_SSIE = 2;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_s      = sda_q[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;

  p_start_stop_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import i2c_rx_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          ten_bit_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          full_i,
  input  logic          ovf_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          sda_pull_o,
  output logic          data_ok_o,
  output logic          data_nack_o,
  output logic [DW-1:0] rx_byte_o
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] shreg, byte_now;
  logic [CW-1:0] cnt;
  phase_e        phase, nxt_phase;
  bit_st_e       bst;
  logic          ack_q, pull_q, dec_ack, dec_ok, dec_nack, hit;

  assign byte_now = {shreg[DW-2:0], sda_i};

  always_comb begin
    nxt_phase = phase;
    dec_ack   = 1'b0;
    dec_ok    = 1'b0;
    dec_nack  = 1'b0;
    hit       = 1'b0;
    case (phase)
      PH_ADDR1: begin
        if (ten_bit_i)
          hit = (byte_now[7:3] == 5'b11110) && (byte_now[2:1] == own_addr_i[9:8]) && !byte_now[0];
        else
          hit = (byte_now[7:1] == own_addr_i[6:0]) && !byte_now[0];
        dec_ack   = hit;
        nxt_phase = !hit ? PH_SKIP : (ten_bit_i ? PH_ADDR2 : PH_DATA);
      end
      PH_ADDR2: begin
        hit       = (byte_now == own_addr_i[7:0]);
        dec_ack   = hit;
        nxt_phase = hit ? PH_DATA : PH_SKIP;
      end
      PH_DATA: begin
        if (full_i || ovf_i) dec_nack = 1'b1;
        else begin
          dec_ok  = 1'b1;
          dec_ack = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg       <= '0;
      cnt         <= '0;
      phase       <= PH_SKIP;
      bst         <= BS_IDLE;
      ack_q       <= 1'b0;
      pull_q      <= 1'b0;
      data_ok_o   <= 1'b0;
      data_nack_o <= 1'b0;
    end else begin
      data_ok_o   <= 1'b0;
      data_nack_o <= 1'b0;
      if (!enable_i) begin
        bst    <= BS_IDLE;
        pull_q <= 1'b0;
      end else if (start_i) begin
        bst    <= BS_BITS;
        phase  <= PH_ADDR1;
        cnt    <= '0;
        pull_q <= 1'b0;
      end else if (stop_i) begin
        bst    <= BS_IDLE;
        pull_q <= 1'b0;
      end else begin
        case (bst)
          BS_BITS: if (scl_rise_i) begin
            shreg <= byte_now;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) begin
              bst         <= BS_WAIT;
              ack_q       <= dec_ack;
              phase       <= nxt_phase;
              data_ok_o   <= dec_ok;
              data_nack_o <= dec_nack;
            end
          end
          BS_WAIT: if (scl_fall_i) begin
            pull_q <= ack_q;
            bst    <= BS_SLOT;
          end
          BS_SLOT: if (scl_rise_i) bst <= BS_HOLD;
          BS_HOLD: if (scl_fall_i) begin
            pull_q <= 1'b0;
            cnt    <= '0;
            bst    <= (phase == PH_SKIP) ? BS_IDLE : BS_BITS;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign rx_byte_o  = shreg;

  p_pull_in_slot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> (bst == BS_SLOT || bst == BS_HOLD));
  p_pull_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> $past(scl_fall_i));
  p_ok_nack_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_ok_o && data_nack_o));
  p_off_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> !sda_pull_o && !data_ok_o && !data_nack_o);
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
  import i2c_rx_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              data_ok_i,
  input  logic              data_nack_i,
  input  logic [DW-1:0]     rx_byte_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              enable_o,
  output logic              ten_bit_o,
  output logic [AW-1:0]     own_addr_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              irq_o
);
  localparam int HW = AW - DW;

  logic [2:0]    ctrl_q;
  logic [DW-1:0] addr_lo_q, rxbuf_q;
  logic [HW-1:0] addr_hi_q;
  logic          full_q, ovf_q, s_q, p_q, irq_q;
  logic          wr_stat, rd_buf, en_start, en_stop, ss_irq;

  assign wr_stat  = reg_wr_i && (reg_addr_i == REG_STAT);
  assign rd_buf   = reg_rd_i && (reg_addr_i == REG_RXBUF);
  assign en_start = start_i && ctrl_q[CT_EN];
  assign en_stop  = stop_i && ctrl_q[CT_EN];
  assign ss_irq   = ctrl_q[CT_SSIE] && (en_start || en_stop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      rxbuf_q   <= '0;
      full_q    <= 1'b0;
      ovf_q     <= 1'b0;
      s_q       <= 1'b0;
      p_q       <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == REG_CTRL)    ctrl_q    <= reg_wdata_i[2:0];
      if (reg_wr_i && reg_addr_i == REG_ADDR_LO) addr_lo_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == REG_ADDR_HI) addr_hi_q <= reg_wdata_i[HW-1:0];

      if (data_ok_i) begin
        rxbuf_q <= rx_byte_i;
        full_q  <= 1'b1;
      end else if (rd_buf) full_q <= 1'b0;

      if (data_nack_i && full_q)            ovf_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_OVF]) ovf_q <= 1'b0;

      if (data_ok_i || data_nack_i || ss_irq)  irq_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_IRQ]) irq_q <= 1'b0;

      if (en_start) begin
        s_q <= 1'b1;
        p_q <= 1'b0;
      end else if (en_stop) begin
        s_q <= 1'b0;
        p_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL:    reg_rdata_o[2:0] = ctrl_q;
      REG_STAT: begin
        reg_rdata_o[ST_FULL] = full_q;
        reg_rdata_o[ST_OVF]  = ovf_q;
        reg_rdata_o[ST_S]    = s_q;
        reg_rdata_o[ST_P]    = p_q;
        reg_rdata_o[ST_IRQ]  = irq_q;
      end
      REG_RXBUF:   reg_rdata_o = rxbuf_q;
      REG_ADDR_LO: reg_rdata_o = addr_lo_q;
      REG_ADDR_HI: reg_rdata_o[HW-1:0] = addr_hi_q;
      default: ;
    endcase
  end

  assign enable_o   = ctrl_q[CT_EN];
  assign ten_bit_o  = ctrl_q[CT_TEN];
  assign own_addr_o = {addr_hi_q, addr_lo_q};
  assign full_o     = full_q;
  assign ovf_o      = ovf_q;
  assign irq_o      = irq_q;

  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ok_i |=> full_q && irq_q && (rxbuf_q == $past(rx_byte_i)));
  p_refuse_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_nack_i && full_q) |=> ovf_q && irq_q && $stable(rxbuf_q));
  p_refuse_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_nack_i |=> irq_q && $stable(rxbuf_q));
  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_stat && reg_wdata_i[ST_OVF])) |=> ovf_q);
  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_buf && !data_ok_i) |=> !full_q);
  p_sp_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_q && p_q));
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
  import i2c_rx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          enable, ten_bit, full, ovf, data_ok, data_nack;
  logic [AW-1:0] own_addr;
  logic [DW-1:0] rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_rx_engine #(.DW(DW), .AW(AW)) u_engine (
    .clk_i, .rst_ni,
    .enable_i(enable), .ten_bit_i(ten_bit), .own_addr_i(own_addr),
    .full_i(full), .ovf_i(ovf), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_pull_o, .data_ok_o(data_ok), .data_nack_o(data_nack), .rx_byte_o(rx_byte)
  );

  i2c_rx_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .data_ok_i(data_ok), .data_nack_i(data_nack), .rx_byte_i(rx_byte),
    .start_i(start_det), .stop_i(stop_det),
    .enable_o(enable), .ten_bit_o(ten_bit), .own_addr_o(own_addr),
    .full_o(full), .ovf_o(ovf), .irq_o
  );
endmodule

// File: tb/i2c_rx_slave_tb.sv
module i2c_rx_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_pull;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq;
  wire        sda_bus = sda_m & ~sda_pull;

  i2c_rx_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  int n_tests = 0, n_fail = 0;
  bit    exp_ack_q[$];
  string exp_req_q[$];
  bit    got_ack;
  event  ack_ev;
  logic [7:0] rd;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for acknowledge bits
  initial forever begin
    @(ack_ev);
    if (exp_ack_q.size() == 0) check("SB", 1, 0);
    else begin
      string r;
      bit e;
      e = exp_ack_q.pop_front();
      r = exp_req_q.pop_front();
      check(r, got_ack, e);
    end
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    exp_ack_q.push_back(exp_ack);
    exp_req_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0;
    end
    wq();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    got_ack = ~sda_bus;
    -> ack_ev;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check("WATCHDOG", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset values
    reg_read(3'd1, rd); check("R9 status", rd, 8'h00);
    reg_read(3'd0, rd); check("R9 ctrl", rd, 8'h00);
    reg_read(3'd3, rd); check("R9 addr_lo", rd, 8'h00);
    check("R9 irq", irq, 0);

    // R10 disabled: no ack, no S/P
    reg_write(3'd3, 8'h52);
    bus_start();
    send_byte(8'hA4, 1'b0, "R10 addr while disabled");
    bus_stop();
    reg_read(3'd1, rd); check("R10 status", rd, 8'h00);

    // R1/R3/R7 basic 7-bit write
    reg_write(3'd0, 8'h01);
    bus_start();
    reg_read(3'd1, rd); check("R7 S after start", rd, 8'h04);
    send_byte(8'hA4, 1'b1, "R1 7-bit match");
    send_byte(8'h5A, 1'b1, "R3 data ack");
    check("R3 irq", irq, 1);
    check("R8 released", sda_pull, 0);
    reg_read(3'd1, rd); check("R3 status", rd, 8'h15);
    bus_stop();
    reg_read(3'd1, rd); check("R7 P after stop", rd, 8'h19);
    reg_read(3'd2, rd); check("R3 rxbuf", rd, 8'h5A);
    reg_read(3'd1, rd); check("R6 read clears full", rd, 8'h18);
    reg_write(3'd1, 8'h10);
    reg_read(3'd1, rd); check("R6 irq clear", rd, 8'h08);

    // R4/R5/R6 overflow path
    bus_start();
    send_byte(8'hA4, 1'b1, "R1 match");
    send_byte(8'h11, 1'b1, "R3 data ack");
    send_byte(8'h22, 1'b0, "R4 nack on full");
    reg_read(3'd1, rd); check("R4 status full+ovf", rd, 8'h17);
    reg_read(3'd2, rd); check("R4 rxbuf kept", rd, 8'h11);
    reg_write(3'd1, 8'h10);
    send_byte(8'h33, 1'b0, "R5 nack on ovf");
    check("R5 irq", irq, 1);
    reg_read(3'd1, rd); check("R5 status", rd, 8'h16);
    reg_read(3'd2, rd); check("R5 rxbuf kept", rd, 8'h11);
    reg_write(3'd1, 8'h02);
    reg_read(3'd1, rd); check("R6 ovf clear", rd, 8'h14);
    send_byte(8'h44, 1'b1, "R3 ack after clear");
    reg_read(3'd2, rd); check("R3 rxbuf new", rd, 8'h44);
    bus_stop();

    // R1 wrong address, R11 read direction
    reg_write(3'd1, 8'h12);
    bus_start();
    send_byte(8'hA6, 1'b0, "R1 mismatch");
    send_byte(8'h77, 1'b0, "R1 data ignored");
    reg_read(3'd1, rd); check("R1 no full no irq", rd & 8'h13, 8'h00);
    bus_stop();
    bus_start();
    send_byte(8'hA5, 1'b0, "R11 read dir");
    bus_stop();

    // R2 10-bit
    reg_write(3'd4, 8'h02);
    reg_write(3'd3, 8'h3C);
    reg_write(3'd0, 8'h03);
    bus_start();
    send_byte(8'hF4, 1'b1, "R2 first byte");
    send_byte(8'h3C, 1'b1, "R2 second byte");
    send_byte(8'h99, 1'b1, "R2 data");
    reg_read(3'd2, rd); check("R2 rxbuf", rd, 8'h99);
    bus_start();
    send_byte(8'hF4, 1'b1, "R2 first byte again");
    send_byte(8'h3D, 1'b0, "R2 low mismatch");
    send_byte(8'h55, 1'b0, "R2 data ignored");
    reg_read(3'd1, rd); check("R2 not full", rd & 8'h01, 8'h00);
    reg_read(3'd2, rd); check("R2 rxbuf kept", rd, 8'h99);
    bus_stop();

    // R7 start/stop interrupts
    reg_write(3'd0, 8'h05);
    reg_write(3'd1, 8'h12);
    check("R7 irq cleared", irq, 0);
    bus_start();
    check("R7 irq on start", irq, 1);
    reg_write(3'd1, 8'h10);
    check("R7 irq cleared again", irq, 0);
    bus_stop();
    check("R7 irq on stop", irq, 1);
    check("R8 idle released", sda_pull, 0);

    repeat (4) @(posedge clk);
    check("SB queue drained", exp_ack_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule